// File: doc/BRIEF.md
# Two-Region Key Unlock Guard

This block keeps two memory regions, a program region and a data region, write-protected until software proves intent. Each region has its own key register. Writing the region's first key value and then its second key value, back to back, opens that region. Any wrong value along the way latches the region into a failed condition that only a reset clears, so a wrong guess cannot be followed by a retry.

Software closes a region again by writing the status register with that region's open bit cleared. Reads of the status register show the live open flags, and reads of either key register always give zero. A 2-bit condition code per region is brought out for diagnostics. The four key values and the two status bit positions are parameters.

Top module: `region_key_lock`

## Requirements
- R1: After reset both regions are in condition 0 (locked; codes are 0 locked, 1 first key seen, 2 open, 3 failed), both open flags are low and the status readback is zero.
- R2: A key write to a locked region moves it to code 1 if the value equals that region's first key and to code 3 otherwise, visible one clock after the write.
- R3: A key write to a region in code 1 moves it to code 2 if the value equals that region's second key and to code 3 otherwise.
- R4: A region in code 3 stays in code 3 whatever key or status writes arrive, until reset.
- R5: Key writes to a region in code 2 are ignored; it stays open.
- R6: A status write with bit 1 clear returns the program region from code 1 or 2 to code 0; bit 3 clear does the same for the data region; a set bit leaves its region unchanged; a relock wins over a key write to the same region in the same cycle.
- R7: The status readback has bit 1 high exactly when the program region is open, bit 3 high exactly when the data region is open, and all other bits zero; the written values of bits 1 and 3 are never stored.
- R8: The key readback is zero at all times, including right after a key write.
- R9: A key write strobe for one region never changes the other region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_key_we | input | 1 | Write strobe of the program-region key register |
| data_key_we | input | 1 | Write strobe of the data-region key register |
| key_wdata | input | 8 | Byte written to a key register |
| stat_we | input | 1 | Write strobe of the status register |
| stat_wdata | input | 8 | Byte written to the status register |
| key_rdata | output | 8 | Readback of either key register |
| stat_rdata | output | 8 | Readback of the open bits of the status register |
| prog_open | output | 1 | Program region writable |
| data_open | output | 1 | Data region writable |
| prog_state | output | 2 | Program-region condition code |
| data_state | output | 2 | Data-region condition code |

## Verification
Every result of this block is registered once: a key or status strobe seen at a rising edge shows up in the condition codes, open flags and status readback immediately after that edge, and no output depends combinationally on an input. The bench drives strobes on falling edges, advances a behavioural model on the rising edge from the same inputs, and compares every output with the model on the following falling edge, so each stimulus is checked exactly one cycle later and on every cycle after. Sequences cover wrong first and second keys, writes after failure or while open, same-cycle relock and key write, and a reset in mid-run.

// File: rtl/region_key_lock.sv
module region_key_lock #(
  parameter logic [7:0] PROG_KEY_A = 8'h5A,
  parameter logic [7:0] PROG_KEY_B = 8'hC3,
  parameter logic [7:0] DATA_KEY_A = 8'h96,
  parameter logic [7:0] DATA_KEY_B = 8'h69,
  parameter int         PROG_BIT   = 1,
  parameter int         DATA_BIT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_key_we,
  input  logic       data_key_we,
  input  logic [7:0] key_wdata,
  input  logic       stat_we,
  input  logic [7:0] stat_wdata,
  output logic [7:0] key_rdata,
  output logic [7:0] stat_rdata,
  output logic       prog_open,
  output logic       data_open,
  output logic [1:0] prog_state,
  output logic [1:0] data_state
);

  localparam logic [1:0] ST_LOCK  = 2'd0;
  localparam logic [1:0] ST_FIRST = 2'd1;
  localparam logic [1:0] ST_OPEN  = 2'd2;
  localparam logic [1:0] ST_FAIL  = 2'd3;

  logic [1:0][1:0] st_q;
  logic [1:0]      kwe;
  logic            unused_wdata;

  assign kwe          = {data_key_we, prog_key_we};
  assign unused_wdata = ^stat_wdata;

  for (genvar g = 0; g < 2; g++) begin : g_region
    localparam logic [7:0] KEY_A = (g == 0) ? PROG_KEY_A : DATA_KEY_A;
    localparam logic [7:0] KEY_B = (g == 0) ? PROG_KEY_B : DATA_KEY_B;
    localparam int         RBIT  = (g == 0) ? PROG_BIT : DATA_BIT;

    logic       relock;
    logic [1:0] st_d;

    assign relock = stat_we && !stat_wdata[RBIT];

    always_comb begin
      st_d = st_q[g];
      if (st_q[g] != ST_FAIL && relock)
        st_d = ST_LOCK;
      else if (kwe[g]) begin
        case (st_q[g])
          ST_LOCK:  st_d = (key_wdata == KEY_A) ? ST_FIRST : ST_FAIL;
          ST_FIRST: st_d = (key_wdata == KEY_B) ? ST_OPEN  : ST_FAIL;
          default:  st_d = st_q[g];
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[g] <= ST_LOCK;
      else        st_q[g] <= st_d;
    end

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == ST_FAIL |=> st_q[g] == ST_FAIL); // R4

    AST_NO_SKIP_TO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      st_q[g] == ST_LOCK |=> st_q[g] != ST_OPEN); // R3

    AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] != ST_OPEN && !kwe[g]) |=> st_q[g] != ST_OPEN); // R9

    AST_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_we && !stat_wdata[RBIT] && st_q[g] != ST_FAIL) |=> st_q[g] == ST_LOCK); // R6

    AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_OPEN && !stat_we) |=> st_q[g] == ST_OPEN); // R5
  end

  assign prog_state = st_q[0];
  assign data_state = st_q[1];
  assign prog_open  = (st_q[0] == ST_OPEN);
  assign data_open  = (st_q[1] == ST_OPEN);
  assign key_rdata  = '0;

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[PROG_BIT] = prog_open;
    stat_rdata[DATA_BIT] = data_open;
  end

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_state == ST_OPEN) |-> stat_rdata[PROG_BIT]); // R7

endmodule

// File: tb/region_key_lock_tb.sv
module region_key_lock_tb_top;
  localparam logic [7:0] PKA = 8'h5A, PKB = 8'hC3, DKA = 8'h96, DKB = 8'h69;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_key_we = 0, data_key_we = 0, stat_we = 0;
  logic [7:0] key_wdata = 0, stat_wdata = 0;
  logic [7:0] key_rdata, stat_rdata;
  logic prog_open, data_open;
  logic [1:0] prog_state, data_state;

  int compared = 0, mismatched = 0;
  int ms [2];
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  region_key_lock dut_i (
    .clk(clk), .rst_n(rst_n), .prog_key_we(prog_key_we), .data_key_we(data_key_we),
    .key_wdata(key_wdata), .stat_we(stat_we), .stat_wdata(stat_wdata),
    .key_rdata(key_rdata), .stat_rdata(stat_rdata), .prog_open(prog_open),
    .data_open(data_open), .prog_state(prog_state), .data_state(data_state));

  function automatic int step(int s, bit we, int v, int ka, int kb, bit rel);
    if (s == 3) return 3;
    if (rel) return 0;
    if (!we) return s;
    if (s == 0) return (v == ka) ? 1 : 3;
    if (s == 1) return (v == kb) ? 2 : 3;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms[0] = 0; ms[1] = 0;
    end else begin
      ms[0] = step(ms[0], prog_key_we, key_wdata, PKA, PKB, stat_we && !stat_wdata[1]);
      ms[1] = step(ms[1], data_key_we, key_wdata, DKA, DKB, stat_we && !stat_wdata[3]);
    end
  end

  task automatic cmp(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cmp("prog_state", prog_state, ms[0]);
      cmp("data_state", data_state, ms[1]);
      cmp("prog_open", prog_open, ms[0] == 2);
      cmp("data_open", data_open, ms[1] == 2);
      cmp("stat_rdata R7", stat_rdata, ((ms[0] == 2) << 1) | ((ms[1] == 2) << 3));
      cmp("key_rdata R8", key_rdata, 0);
    end
  end

  task automatic cyc(bit pw, bit dw, logic [7:0] kv, bit sw, logic [7:0] sv);
    @(negedge clk);
    prog_key_we = pw; data_key_we = dw; key_wdata = kv; stat_we = sw; stat_wdata = sv;
    @(negedge clk);
    prog_key_we = 0; data_key_we = 0; stat_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1ms;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(2);
    cur_req = "R1"; cmp("reset prog_state R1", prog_state, 0); cmp("reset stat R1", stat_rdata, 0);
    cur_req = "R2"; cyc(1, 0, PKA, 0, 0); cmp("prog first R2", prog_state, 1);
    cur_req = "R3"; cyc(1, 0, PKB, 0, 0); cmp("prog open R3", prog_state, 2);
    cur_req = "R7"; cmp("stat bit1 R7", stat_rdata, 8'h02);
    cur_req = "R6"; cyc(0, 0, 0, 1, 8'hFF); cmp("set bits keep R6", prog_state, 2);
    cur_req = "R5"; cyc(1, 0, 8'h00, 0, 0); cyc(1, 0, PKA, 0, 0); cmp("open ignores key R5", prog_state, 2);
    cur_req = "R9"; cyc(0, 1, DKA, 0, 0); cmp("data first R9", data_state, 1); cmp("prog untouched R9", prog_state, 2);
    cur_req = "R3"; cyc(0, 1, 8'h11, 0, 0); cmp("data wrong second R3", data_state, 3);
    cur_req = "R4"; cyc(0, 1, DKA, 0, 0); cyc(0, 1, DKB, 0, 0); cmp("fail sticky R4", data_state, 3);
    cur_req = "R6"; cyc(0, 0, 0, 1, 8'h00); cmp("prog relock R6", prog_state, 0);
    cur_req = "R4"; cmp("fail ignores relock R4", data_state, 3);
    cur_req = "R6"; cyc(1, 0, PKA, 1, 8'hF5); cmp("relock beats key R6", prog_state, 0);
    cur_req = "R2"; cyc(1, 0, PKB, 0, 0); cmp("prog wrong first R2", prog_state, 3);
    cur_req = "R8"; cmp("key readback R8", key_rdata, 0);
    cur_req = "R1"; @(negedge clk); rst_n = 0; idle(1); rst_n = 1; idle(1);
    cmp("mid reset prog R1", prog_state, 0); cmp("mid reset data R1", data_state, 0);
    cur_req = "R9"; cyc(0, 1, DKA, 0, 0); cyc(0, 1, DKB, 0, 0); cmp("data open R9", data_state, 2);
    cur_req = "R2"; cyc(1, 0, PKA, 0, 0); cmp("prog first again R2", prog_state, 1);
    cur_req = "R7"; cmp("stat bit3 R7", stat_rdata, 8'h08);
    cur_req = "R6"; cyc(0, 0, 0, 1, 8'hF7); cmp("data relock R6", data_state, 0); cmp("prog kept R6", prog_state, 1);
    cur_req = "R3"; cyc(1, 1, PKB, 0, 0); cmp("prog open again R3", prog_state, 2); cmp("data wrong first R2", data_state, 3);
    cur_req = "R7"; cmp("stat final R7", stat_rdata, 8'h02);
    idle(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule